// File: doc/BRIEF.md
# Unary Bit-Manipulation Decode and Execute Slice

This block sits beside the integer pipeline of a RISC-V style core and handles two single-source bit-manipulation operations: byte reversal across the whole register, and the OR-combine that collapses each byte to all-ones or all-zeros. Each cycle it takes a 32-bit instruction word and the value of the first source register. It decides whether the word is one of the operations it owns, and computes the result. Register-file access, pipeline control and trap handling belong to the surrounding core.

The register width is a parameter, 32 or 64. The byte-reverse encoding differs between the two widths. The encoding that belongs to the other width is flagged as illegal so that the core can raise an exception. No word-sized variant of byte reversal exists, so the 64-bit-only immediate-word major opcode with the byte-reverse function bits is left undecoded. Every other instruction is reported as not handled, with a zero result.

All outputs are registered, so a decision and its result appear one clock after the instruction is presented. The reset is synchronous and active high.

Top module: `bitop_unary_unit`

## Requirements
- R1: While reset is high at a clock edge, the next outputs are valid=0, illegal=0, result=0, and both index outputs are 0.
- R2: Byte reverse is decoded when funct3 (bits 14:12) is 101, the opcode (bits 6:0) is 0010011, and bits 31:20 hold the native value: 0x698 for XLEN=32 or 0x6B8 for XLEN=64. Valid is then 1 and result byte k equals source byte NBYTES-1-k, so source byte 0 lands in the top byte.
- R3: The byte-reverse bits 31:20 value of the other width (0x6B8 on XLEN=32, 0x698 on XLEN=64), with funct3 101 and opcode 0010011, gives illegal=1, valid=0 and result=0.
- R4: Opcode 0011011 is never decoded, whatever bits 31:20 hold, including either byte-reverse value. It gives valid=0, illegal=0 and result=0.
- R5: OR-combine is decoded when bits 31:20 are 0x287, funct3 is 101 and the opcode is 0010011. Valid is then 1, and each result byte is 0xFF when the matching source byte is nonzero and 0x00 otherwise.
- R6: Any other word, including a supported bits 31:20 value with a funct3 other than 101, gives valid=0, illegal=0 and result=0.
- R7: The destination index output carries instruction bits 11:7 and the source index output carries bits 19:15, for every word, decoded or not.
- R8: Every output reflects the instruction and source presented at the previous rising clock edge. The latency is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_instr | input | 32 | Instruction word |
| i_src | input | XLEN | First source register value |
| o_valid | output | 1 | A supported operation was decoded |
| o_illegal | output | 1 | Byte-reverse encoding of the other width |
| o_result | output | XLEN | Operation result, zero unless valid |
| o_rd_idx | output | 5 | Destination register index |
| o_rs1_idx | output | 5 | Source register index |

## Verification
The bench runs a 64-bit and a 32-bit instance side by side on the same words. This catches a design that swapped the two native encodings or accepted both widths: such a design would show valid where illegal is expected on one of the instances. It also presents the byte-reverse function bits under the word-form opcode and under a wrong funct3, where a decoder that ignores the opcode or the funct3 would assert valid. Source values with zero, single-bit and full bytes expose an OR-combine that tests the wrong bits, and a reversal that mirrors bits or stops at 32 bits.

// File: rtl/bitop_unary_pkg.sv
package bitop_unary_pkg;

  localparam logic [6:0]  OPC_IMM        = 7'b0010011;
  localparam logic [6:0]  OPC_IMM_WORD   = 7'b0011011;
  localparam logic [2:0]  F3_UNARY       = 3'b101;
  localparam logic [11:0] F12_BREV_W32   = 12'h698;
  localparam logic [11:0] F12_BREV_W64   = 12'h6B8;
  localparam logic [11:0] F12_ORCOMB     = 12'h287;

  typedef enum logic [1:0] {
    OPK_NONE    = 2'd0,
    OPK_BREV    = 2'd1,
    OPK_ORCOMB  = 2'd2,
    OPK_FOREIGN = 2'd3
  } op_kind_t;

  typedef struct packed {
    logic [11:0] f12;
    logic [4:0]  rs1;
    logic [2:0]  f3;
    logic [4:0]  rd;
    logic [6:0]  opc;
  } itype_t;

endpackage

// File: rtl/bitop_unary_decode.sv
module bitop_unary_decode
  import bitop_unary_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0] instr,
  output op_kind_t    kind,
  output logic [4:0]  rd_idx,
  output logic [4:0]  rs1_idx
);

  localparam logic [11:0] F12_NATIVE  = (XLEN == 64) ? F12_BREV_W64 : F12_BREV_W32;
  localparam logic [11:0] F12_OTHER   = (XLEN == 64) ? F12_BREV_W32 : F12_BREV_W64;

  itype_t fields;
  logic   unary_slot;

  always_comb begin
    fields     = itype_t'(instr);
    unary_slot = (fields.opc == OPC_IMM) && (fields.f3 == F3_UNARY);
    kind       = OPK_NONE;
    if (unary_slot) begin
      if (fields.f12 == F12_NATIVE)      kind = OPK_BREV;
      else if (fields.f12 == F12_OTHER)  kind = OPK_FOREIGN;
      else if (fields.f12 == F12_ORCOMB) kind = OPK_ORCOMB;
    end
    rd_idx  = fields.rd;
    rs1_idx = fields.rs1;
  end

endmodule

// File: rtl/bitop_byte_reverse.sv
module bitop_byte_reverse #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] din,
  output logic [XLEN-1:0] dout
);

  localparam int NBYTES = XLEN / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign dout[8*(NBYTES-1-b) +: 8] = din[8*b +: 8];
  end

endmodule

// File: rtl/bitop_or_combine.sv
module bitop_or_combine #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] din,
  output logic [XLEN-1:0] dout
);

  localparam int NBYTES = XLEN / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign dout[8*b +: 8] = {8{|din[8*b +: 8]}};
  end

endmodule

// File: rtl/bitop_unary_unit.sv
module bitop_unary_unit
  import bitop_unary_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     i_instr,
  input  logic [XLEN-1:0] i_src,
  output logic            o_valid,
  output logic            o_illegal,
  output logic [XLEN-1:0] o_result,
  output logic [4:0]      o_rd_idx,
  output logic [4:0]      o_rs1_idx
);

  op_kind_t        kind;
  logic [4:0]      rd_c, rs1_c;
  logic [XLEN-1:0] brev_c, orc_c, res_c;

  bitop_unary_decode #(.XLEN(XLEN)) u_dec (
    .instr   (i_instr),
    .kind    (kind),
    .rd_idx  (rd_c),
    .rs1_idx (rs1_c)
  );

  bitop_byte_reverse #(.XLEN(XLEN)) u_brev (
    .din  (i_src),
    .dout (brev_c)
  );

  bitop_or_combine #(.XLEN(XLEN)) u_orc (
    .din  (i_src),
    .dout (orc_c)
  );

  always_comb begin
    unique case (kind)
      OPK_BREV:   res_c = brev_c;
      OPK_ORCOMB: res_c = orc_c;
      default:    res_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid   <= 1'b0;
      o_illegal <= 1'b0;
      o_result  <= '0;
      o_rd_idx  <= '0;
      o_rs1_idx <= '0;
    end else begin
      o_valid   <= (kind == OPK_BREV) || (kind == OPK_ORCOMB);
      o_illegal <= (kind == OPK_FOREIGN);
      o_result  <= res_c;
      o_rd_idx  <= rd_c;
      o_rs1_idx <= rs1_c;
    end
  end

endmodule

// File: rtl/bitop_unary_checker.sv
module bitop_unary_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic [31:0]     i_instr,
  input logic [XLEN-1:0] i_src,
  input logic            o_valid,
  input logic            o_illegal,
  input logic [XLEN-1:0] o_result,
  input logic [4:0]      o_rd_idx,
  input logic [4:0]      o_rs1_idx
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!o_valid && !o_illegal && o_result == '0));

  assert_excl_flags_R3: assert property (@(posedge clk) disable iff (rst)
    !(o_valid && o_illegal));

  assert_word_form_R4: assert property (@(posedge clk) disable iff (rst)
    (i_instr[6:0] == 7'b0011011) |=> (!o_valid && !o_illegal));

  assert_orcomb_valid_R5: assert property (@(posedge clk) disable iff (rst)
    (i_instr == {12'h287, i_instr[19:15], 3'b101, i_instr[11:7], 7'b0010011}
     && i_src == '0) |=> (o_valid && o_result == '0));

  assert_zero_result_R6: assert property (@(posedge clk) disable iff (rst)
    !o_valid |-> (o_result == '0));

  assert_index_pass_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (o_rd_idx == $past(i_instr[11:7]) && o_rs1_idx == $past(i_instr[19:15])));

endmodule

bind bitop_unary_unit bitop_unary_checker #(.XLEN(XLEN)) u_chk (.*);

// File: tb/bitop_unary_unit_tb.sv
module bitop_unary_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [63:0] src = '0;

  logic        v64, il64, v32, il32;
  logic [63:0] r64;
  logic [31:0] r32;
  logic [4:0]  rd64, rs64, rd32, rs32;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bitop_unary_unit #(.XLEN(64)) u_dut (
    .clk(clk), .rst(rst), .i_instr(instr), .i_src(src),
    .o_valid(v64), .o_illegal(il64), .o_result(r64),
    .o_rd_idx(rd64), .o_rs1_idx(rs64)
  );

  bitop_unary_unit #(.XLEN(32)) u_dut_w32 (
    .clk(clk), .rst(rst), .i_instr(instr), .i_src(src[31:0]),
    .o_valid(v32), .o_illegal(il32), .o_result(r32),
    .o_rd_idx(rd32), .o_rs1_idx(rs32)
  );

  // reference model: behavioural, per width
  typedef struct {
    bit          v;
    bit          il;
    logic [63:0] r;
    logic [4:0]  rd;
    logic [4:0]  rs;
    string       tag;
  } exp_t;

  function automatic exp_t model(int xlen, logic [31:0] w, logic [63:0] s);
    exp_t e;
    int nb = xlen / 8;
    logic [11:0] mine  = (xlen == 64) ? 12'h6B8 : 12'h698;
    logic [11:0] other = (xlen == 64) ? 12'h698 : 12'h6B8;
    bit slot = (w[6:0] == 7'b0010011) && (w[14:12] == 3'b101);
    e.v = 0; e.il = 0; e.r = '0; e.tag = "R6";
    e.rd = w[11:7]; e.rs = w[19:15];
    if (w[6:0] == 7'b0011011) e.tag = "R4";
    if (slot && w[31:20] == mine) begin
      e.v = 1; e.tag = "R2";
      for (int b = 0; b < nb; b++)
        e.r[8*(nb-1-b) +: 8] = s[8*b +: 8];
    end else if (slot && w[31:20] == other) begin
      e.il = 1; e.tag = "R3";
    end else if (slot && w[31:20] == 12'h287) begin
      e.v = 1; e.tag = "R5";
      for (int b = 0; b < nb; b++)
        e.r[8*b +: 8] = (s[8*b +: 8] != 0) ? 8'hFF : 8'h00;
    end
    return e;
  endfunction

  task automatic cmp(string who, string tag, logic [63:0] got, logic [63:0] exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s %s: got %h expected %h", tag, who, what, got, exp);
    end
  endtask

  task automatic check_all(exp_t e64, exp_t e32);
    // outputs follow the inputs of the previous edge (R8)
    cmp("w64", e64.tag, {63'd0, v64},  {63'd0, e64.v},  "valid R8");
    cmp("w64", e64.tag, {63'd0, il64}, {63'd0, e64.il}, "illegal");
    cmp("w64", e64.tag, r64, e64.r, "result");
    cmp("w64", "R7", {59'd0, rd64}, {59'd0, e64.rd}, "rd");
    cmp("w64", "R7", {59'd0, rs64}, {59'd0, e64.rs}, "rs1");
    cmp("w32", e32.tag, {63'd0, v32},  {63'd0, e32.v},  "valid R8");
    cmp("w32", e32.tag, {63'd0, il32}, {63'd0, e32.il}, "illegal");
    cmp("w32", e32.tag, {32'd0, r32}, e32.r, "result");
    cmp("w32", "R7", {59'd0, rd32}, {59'd0, e32.rd}, "rd");
    cmp("w32", "R7", {59'd0, rs32}, {59'd0, e32.rs}, "rs1");
  endtask

  function automatic logic [63:0] pick_src(int i);
    logic [63:0] s = {$urandom, $urandom};
    case (i % 6)
      0: s = '0;
      1: s = 64'h0123_4567_89AB_CDEF;
      2: s = 64'h0000_0100_0080_0001;
      3: s = 64'hFFFF_FFFF_FFFF_FFFF;
      4: for (int b = 0; b < 8; b++) if ($urandom % 2 == 0) s[8*b +: 8] = 8'h00;
      default: ;
    endcase
    return s;
  endfunction

  function automatic logic [31:0] pick_instr(int i);
    logic [4:0] rd  = 5'($urandom);
    logic [4:0] rs1 = 5'($urandom);
    logic [31:0] w;
    case (i % 8)
      0: w = {12'h698, rs1, 3'b101, rd, 7'b0010011};
      1: w = {12'h6B8, rs1, 3'b101, rd, 7'b0010011};
      2: w = {12'h287, rs1, 3'b101, rd, 7'b0010011};
      3: w = {12'h6B8, rs1, 3'b101, rd, 7'b0011011};
      4: w = {12'h698, rs1, 3'b101, rd, 7'b0011011};
      5: w = {12'h6B8, rs1, 3'b001, rd, 7'b0010011};
      6: w = {12'h287, rs1, 3'b100, rd, 7'b0010011};
      default: w = $urandom;
    endcase
    return w;
  endfunction

  initial begin
    exp_t e64, e32;
    process::self().srandom(17);
    instr = 32'hFFFF_FFFF;
    src   = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    e64 = '{v:0, il:0, r:'0, rd:'0, rs:'0, tag:"R1"};
    e32 = e64;
    check_all(e64, e32);
    rst = 0;
    for (int i = 0; i < 480; i++) begin
      instr = pick_instr(i);
      src   = pick_src(i / 8 + i);
      e64 = model(64, instr, src);
      e32 = model(32, instr, src);
      @(negedge clk);
      check_all(e64, e32);
    end
    // R1: reset taken mid-stream clears outputs
    instr = {12'h287, 5'd3, 3'b101, 5'd9, 7'b0010011};
    src = 64'h1;
    rst = 1;
    @(negedge clk);
    e64 = '{v:0, il:0, r:'0, rd:'0, rs:'0, tag:"R1"};
    e32 = e64;
    check_all(e64, e32);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule